// File: doc/BRIEF.md
# UART Receive Framer with Buffer Closing

This block is an asynchronous serial receiver that turns the incoming line into characters and groups those characters into receive buffers. Each stored character leaves on a byte port with a one-cycle write strobe. When a buffer ends, a one-cycle close strobe carries a cause code, and the interrupt line pulses in the same cycle. The next stored character then begins a new buffer. The memory that holds the bytes and the per-buffer records are kept outside this block.

Five events end a buffer:
- a matching control character;
- a framing error;
- the programmed size being reached;
- a run of idle character times;
- an address character arriving while a buffer is open, in a multidrop mode.

There are two multidrop modes. In the plain mode, each address character starts a new buffer and is stored as that buffer's first byte. In the filtering mode, the address is compared with a station address. If it matches, the address and the data after it are kept. If it does not match, everything up to the next address is dropped.

The line is oversampled by a baud tick, 16 ticks per bit by default. Each bit is read at the middle of its period. A start bit that has gone high again by its midpoint is treated as noise and ignored.

Top module: `uart_rx_bufclose`

## Requirements
- R1: A frame is a low start bit, the data bits LSB first, one address bit when a multidrop mode is selected, and exactly one high stop bit. A new start bit may follow the stop bit with no idle gap, and both characters are received.
- R2: With `cfg_len8`=0, a frame carries 7 data bits and every stored byte has bit 7 equal to 0.
- R3: With `cfg_mdrop`=1 (plain multidrop), an address character (address bit 1) closes an open, non-empty buffer with cause 4. It is then stored as the first byte of the new buffer, with no comparison.
- R4: With `cfg_mdrop`=2 (filtering), an address character equal to `cfg_station` is stored and enables the data after it. An address that differs is not stored, closes a non-empty buffer with cause 4, and causes later data characters to be dropped until the next matching address. Data received after reset, before any address, is dropped.
- R5: With `cfg_reject`=0, a stored character equal to `cfg_ctrl_char` closes the buffer with cause 0. With `cfg_reject`=1, it is stored as ordinary data and closes nothing.
- R6: A character whose stop bit is sampled low is not stored and closes the buffer with cause 1, whether or not the buffer is empty. A control-character match on the same character is overridden.
- R7: Storing the character that brings the buffer to `cfg_buf_size` (at least 2) closes it with cause 2. A control-character close on the same character takes priority.
- R8: With a non-empty buffer, `cfg_idle_lim` (non-zero) consecutive idle character times close it with cause 3. An idle character time is the full frame length in bit times with the line high. An empty buffer is never closed by idle time, and a limit of 0 disables the idle close.
- R9: Every close gives a one-cycle `close_stb` with `irq` high in the same cycle. The following character is counted from the start of a new buffer.
- R10: A start bit that is high again at its midpoint (tick 8 of 16) produces no character and no strobe.
- R11: After reset, `out_we`, `close_stb` and `irq` are 0, the buffer is empty and the filter is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | Oversampling tick, OSR ticks per bit |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_mdrop | input | 2 | 0/3 none, 1 plain multidrop, 2 filtering multidrop |
| cfg_station | input | 8 | Station address for filtering mode |
| cfg_ctrl_char | input | 8 | Control character value |
| cfg_reject | input | 1 | 1: control character does not close |
| cfg_idle_lim | input | ILW | Idle character times before close, 0 disables |
| cfg_buf_size | input | SZW | Characters per buffer |
| out_data | output | 8 | Byte to store |
| out_we | output | 1 | Store strobe for out_data |
| close_stb | output | 1 | Buffer-close strobe |
| close_cause | output | 3 | 0 ctrl, 1 error, 2 full, 3 idle, 4 address |
| irq | output | 1 | Interrupt pulse on each close |

## Verification
The characters-per-buffer count cannot be seen directly. If it is wrong, the full-buffer close shows up on a different character than expected, so that close is checked on the exact character that should trigger it, both after earlier closes and after address-started buffers. An error in the filter state shows up on the next data character: the write strobe appears when it should not, or is missing. An error in the sampler's bit timing shows up within one frame, as a wrong byte, a false framing error, or a missing store about half a bit after the stop-bit midpoint. The idle-run counter is checked against both a non-empty and an empty buffer.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int MAX_BITS = 9;

  typedef enum logic [2:0] {
    CZ_CTRL = 3'd0,
    CZ_ERR  = 3'd1,
    CZ_FULL = 3'd2,
    CZ_IDLE = 3'd3,
    CZ_ADDR = 3'd4
  } close_cause_e;

  typedef enum logic [2:0] {
    SM_IDLE,
    SM_START,
    SM_BITS,
    SM_STOP,
    SM_WAITHI
  } smp_state_e;
endpackage

// File: rtl/urx_sampler.sv
module urx_sampler
  import urx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  input  logic       len8,
  input  logic       addr_en,
  output logic       char_valid,
  output logic [7:0] char_data,
  output logic       char_addr,
  output logic       char_ferr,
  output logic       idle_pulse
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2((MAX_BITS + 2) * OSR + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  smp_state_e          st;
  logic                rx_m, rx_s;
  logic [CW-1:0]       cnt;
  logic [3:0]          bidx;
  logic [MAX_BITS-1:0] shreg;
  logic [IW-1:0]       idle_cnt;
  logic [3:0]          nbits;
  logic [IW-1:0]       frame_last;

  // frame length depends on data width and presence of the address bit
  always_comb begin
    nbits = len8 ? 4'd8 : 4'd7;
    if (addr_en) nbits = nbits + 4'd1;
    frame_last = IW'((int'(nbits) + 2) * OSR - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m       <= 1'b1;
      rx_s       <= 1'b1;
      st         <= SM_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      shreg      <= '0;
      idle_cnt   <= '0;
      char_valid <= 1'b0;
      char_data  <= '0;
      char_addr  <= 1'b0;
      char_ferr  <= 1'b0;
      idle_pulse <= 1'b0;
    end else begin
      rx_m       <= rxd;
      rx_s       <= rx_m;
      char_valid <= 1'b0;
      idle_pulse <= 1'b0;
      if (tick) begin
        unique case (st)
          SM_IDLE: begin
            if (!rx_s) begin
              st       <= SM_START;
              cnt      <= '0;
              idle_cnt <= '0;
            end else if (idle_cnt == frame_last) begin
              idle_cnt   <= '0;
              idle_pulse <= 1'b1;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
          SM_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              if (rx_s) st <= SM_IDLE;
              else begin
                st   <= SM_BITS;
                bidx <= '0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          SM_BITS: begin
            if (cnt == LAST) begin
              cnt         <= '0;
              shreg[bidx] <= rx_s;
              bidx        <= bidx + 4'd1;
              if (bidx == nbits - 4'd1) st <= SM_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          SM_STOP: begin
            if (cnt == LAST) begin
              cnt        <= '0;
              char_valid <= 1'b1;
              char_ferr  <= !rx_s;
              char_data  <= len8 ? shreg[7:0] : {1'b0, shreg[6:0]};
              char_addr  <= addr_en && (len8 ? shreg[8] : shreg[7]);
              st         <= rx_s ? SM_IDLE : SM_WAITHI;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          SM_WAITHI: if (rx_s) st <= SM_IDLE;
          default:   st <= SM_IDLE;
        endcase
      end
    end
  end

  // R10: a start bit high again at its midpoint returns to idle without a character
  a_r10_glitch_rejected: assert property (@(posedge clk) disable iff (rst)
    (st == SM_START && tick && cnt == MID && rx_s) |=> (st == SM_IDLE && !char_valid));

  // R1: the character is reported only from the single stop-bit sample
  a_r1_one_stop: assert property (@(posedge clk) disable iff (rst)
    char_valid |-> ($past(st) == SM_STOP));
endmodule

// File: rtl/urx_bufctl.sv
module urx_bufctl
  import urx_pkg::*;
#(
  parameter int SZW = 8,
  parameter int ILW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           char_valid,
  input  logic [7:0]     char_data,
  input  logic           char_addr,
  input  logic           char_ferr,
  input  logic           idle_pulse,
  input  logic           filt,
  input  logic [7:0]     station,
  input  logic [7:0]     ctrl_char,
  input  logic           reject,
  input  logic [ILW-1:0] idle_lim,
  input  logic [SZW-1:0] buf_size,
  output logic [7:0]     out_data,
  output logic           out_we,
  output logic           close_stb,
  output logic [2:0]     close_cause
);
  logic [SZW-1:0] cnt;
  logic [ILW-1:0] irun;
  logic           accept;
  logic           is_addr, drop_data, is_ctrl;

  always_comb begin
    is_addr   = char_addr;
    drop_data = filt && !accept;
    is_ctrl   = (char_data == ctrl_char) && !reject;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      irun        <= '0;
      accept      <= 1'b0;
      out_data    <= '0;
      out_we      <= 1'b0;
      close_stb   <= 1'b0;
      close_cause <= CZ_CTRL;
    end else begin
      out_we    <= 1'b0;
      close_stb <= 1'b0;
      if (char_valid) begin
        irun <= '0;
        if (char_ferr) begin
          close_stb   <= 1'b1;
          close_cause <= CZ_ERR;
          cnt         <= '0;
        end else if (is_addr) begin
          if (cnt != '0) begin
            close_stb   <= 1'b1;
            close_cause <= CZ_ADDR;
          end
          if (filt && char_data != station) begin
            accept <= 1'b0;
            cnt    <= '0;
          end else begin
            accept   <= 1'b1;
            out_we   <= 1'b1;
            out_data <= char_data;
            cnt      <= SZW'(1);
          end
        end else if (!drop_data) begin
          out_we   <= 1'b1;
          out_data <= char_data;
          if (is_ctrl) begin
            close_stb   <= 1'b1;
            close_cause <= CZ_CTRL;
            cnt         <= '0;
          end else if (cnt + SZW'(1) == buf_size) begin
            close_stb   <= 1'b1;
            close_cause <= CZ_FULL;
            cnt         <= '0;
          end else begin
            cnt <= cnt + SZW'(1);
          end
        end
      end else if (idle_pulse && cnt != '0 && idle_lim != '0) begin
        if (irun + ILW'(1) == idle_lim) begin
          close_stb   <= 1'b1;
          close_cause <= CZ_IDLE;
          cnt         <= '0;
          irun        <= '0;
        end else begin
          irun <= irun + ILW'(1);
        end
      end
    end
  end

  // R6: framing error closes with the error cause and stores nothing
  a_r6_error_closes: assert property (@(posedge clk) disable iff (rst)
    (char_valid && char_ferr) |=> (close_stb && close_cause == CZ_ERR && !out_we));

  // R4: data while the filter is closed is not stored
  a_r4_filtered_drop: assert property (@(posedge clk) disable iff (rst)
    (char_valid && !char_ferr && !char_addr && filt && !accept) |=> !out_we);

  // R5: matching control character with reject clear closes with cause 0
  a_r5_ctrl_close: assert property (@(posedge clk) disable iff (rst)
    (char_valid && !char_ferr && !char_addr && !drop_data && is_ctrl)
      |=> (close_stb && close_cause == CZ_CTRL && out_we));

  // R8: idle time never closes an empty buffer
  a_r8_idle_empty: assert property (@(posedge clk) disable iff (rst)
    (idle_pulse && !char_valid && cnt == '0) |=> !close_stb);

  // R7: the buffer count never reaches the programmed size
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    (buf_size >= SZW'(2) && $stable(buf_size)) |-> (cnt < buf_size));
endmodule

// File: rtl/uart_rx_bufclose.sv
module uart_rx_bufclose
  import urx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int SZW = 8,
  parameter int ILW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rxd,
  input  logic           baud_tick,
  input  logic           cfg_len8,
  input  logic [1:0]     cfg_mdrop,
  input  logic [7:0]     cfg_station,
  input  logic [7:0]     cfg_ctrl_char,
  input  logic           cfg_reject,
  input  logic [ILW-1:0] cfg_idle_lim,
  input  logic [SZW-1:0] cfg_buf_size,
  output logic [7:0]     out_data,
  output logic           out_we,
  output logic           close_stb,
  output logic [2:0]     close_cause,
  output logic           irq
);
  logic       addr_en, filt;
  logic       c_valid, c_addr, c_ferr, c_idle;
  logic [7:0] c_data;

  assign addr_en = (cfg_mdrop == 2'd1) || (cfg_mdrop == 2'd2);
  assign filt    = (cfg_mdrop == 2'd2);

  urx_sampler #(.OSR(OSR)) u_smp (
    .clk        (clk),
    .rst        (rst),
    .tick       (baud_tick),
    .rxd        (rxd),
    .len8       (cfg_len8),
    .addr_en    (addr_en),
    .char_valid (c_valid),
    .char_data  (c_data),
    .char_addr  (c_addr),
    .char_ferr  (c_ferr),
    .idle_pulse (c_idle)
  );

  urx_bufctl #(.SZW(SZW), .ILW(ILW)) u_buf (
    .clk         (clk),
    .rst         (rst),
    .char_valid  (c_valid),
    .char_data   (c_data),
    .char_addr   (c_addr),
    .char_ferr   (c_ferr),
    .idle_pulse  (c_idle),
    .filt        (filt),
    .station     (cfg_station),
    .ctrl_char   (cfg_ctrl_char),
    .reject      (cfg_reject),
    .idle_lim    (cfg_idle_lim),
    .buf_size    (cfg_buf_size),
    .out_data    (out_data),
    .out_we      (out_we),
    .close_stb   (close_stb),
    .close_cause (close_cause)
  );

  assign irq = close_stb;

  // R2: 7-bit mode never stores bit 7
  a_r2_bit7_zero: assert property (@(posedge clk) disable iff (rst)
    (out_we && !cfg_len8 && $stable(cfg_len8)) |-> !out_data[7]);

  // R9: a close strobe lasts a single cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    close_stb |=> !close_stb);
endmodule

// File: tb/tb_uart_rx_bufclose.sv
module tb_uart_rx_bufclose;
  localparam int SZW = 8;
  localparam int ILW = 4;
  localparam int BITCLK = 64;  // 16 ticks x 4 clocks

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           rxd = 1'b1;
  logic           baud_tick;
  logic           cfg_len8 = 1'b1;
  logic [1:0]     cfg_mdrop = 2'd0;
  logic [7:0]     cfg_station = 8'h22;
  logic [7:0]     cfg_ctrl_char = 8'h0D;
  logic           cfg_reject = 1'b0;
  logic [ILW-1:0] cfg_idle_lim = '0;
  logic [SZW-1:0] cfg_buf_size = SZW'(4);
  logic [7:0]     out_data;
  logic           out_we, close_stb, irq;
  logic [2:0]     close_cause;

  int n_chk = 0, n_bad = 0;
  int we_n = 0, cl_n = 0, irq_n = 0;
  logic [7:0] last_b = '0;
  logic [2:0] last_c = '0;
  logic [1:0] tdiv = '0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'd3);

  uart_rx_bufclose #(.OSR(16), .SZW(SZW), .ILW(ILW)) dut (
    .clk(clk), .rst(rst), .rxd(rxd), .baud_tick(baud_tick),
    .cfg_len8(cfg_len8), .cfg_mdrop(cfg_mdrop), .cfg_station(cfg_station),
    .cfg_ctrl_char(cfg_ctrl_char), .cfg_reject(cfg_reject),
    .cfg_idle_lim(cfg_idle_lim), .cfg_buf_size(cfg_buf_size),
    .out_data(out_data), .out_we(out_we), .close_stb(close_stb),
    .close_cause(close_cause), .irq(irq)
  );

  always @(negedge clk) if (!rst) begin
    if (out_we) begin we_n++; last_b = out_data; end
    if (close_stb) begin cl_n++; last_c = close_cause; end
    if (irq) irq_n++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit b8, input bit ha,
                      input bit a, input bit stp, input bit gap);
    rxd = 1'b0; repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < (b8 ? 8 : 7); i++) begin
      rxd = d[i]; repeat (BITCLK) @(negedge clk);
    end
    if (ha) begin rxd = a; repeat (BITCLK) @(negedge clk); end
    rxd = stp; repeat (BITCLK) @(negedge clk);
    rxd = 1'b1;
    if (gap) repeat (BITCLK) @(negedge clk);
  endtask

  // {ferr, data, exp_we, exp_byte, exp_close, exp_cause}
  localparam logic [21:0] VEC [12] = '{
    {1'b0, 8'h41, 1'b1, 8'h41, 1'b0, 3'd0},  // R1 store
    {1'b0, 8'h42, 1'b1, 8'h42, 1'b0, 3'd0},
    {1'b0, 8'h0D, 1'b1, 8'h0D, 1'b1, 3'd0},  // R5 control close
    {1'b0, 8'h10, 1'b1, 8'h10, 1'b0, 3'd0},  // R9 fresh buffer
    {1'b0, 8'h11, 1'b1, 8'h11, 1'b0, 3'd0},
    {1'b0, 8'h12, 1'b1, 8'h12, 1'b0, 3'd0},
    {1'b0, 8'h13, 1'b1, 8'h13, 1'b1, 3'd2},  // R7 full
    {1'b1, 8'h55, 1'b0, 8'h00, 1'b1, 3'd1},  // R6 error
    {1'b0, 8'hFF, 1'b1, 8'hFF, 1'b0, 3'd0},
    {1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 3'd0},
    {1'b1, 8'h0D, 1'b0, 8'h00, 1'b1, 3'd1},  // R6 error beats control
    {1'b0, 8'hA5, 1'b1, 8'hA5, 1'b0, 3'd0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int w0, c0;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11 out_we", int'(out_we), 0);
    chk("R11 close_stb", int'(close_stb), 0);
    chk("R11 irq", int'(irq), 0);
    rst = 1'b0;
    repeat (BITCLK) @(negedge clk);

    for (int v = 0; v < 12; v++) begin
      w0 = we_n; c0 = cl_n;
      send(VEC[v][20:13], 1'b1, 1'b0, 1'b0, !VEC[v][21], 1'b1);
      chk("R1/R5/R6/R7 store count", we_n - w0, int'(VEC[v][12]));
      if (VEC[v][12]) chk("R1 stored byte", int'(last_b), int'(VEC[v][11:4]));
      chk("R5/R6/R7/R9 close count", cl_n - c0, int'(VEC[v][3]));
      if (VEC[v][3]) chk("R5/R6/R7 cause", int'(last_c), int'(VEC[v][2:0]));
    end

    // R8 idle run closes a non-empty buffer, never an empty one
    c0 = cl_n; cfg_idle_lim = ILW'(2);
    repeat (1600) @(negedge clk);
    chk("R8 idle close count", cl_n - c0, 1);
    chk("R8 idle cause", int'(last_c), 3);
    c0 = cl_n;
    repeat (1600) @(negedge clk);
    chk("R8 empty buffer no close", cl_n - c0, 0);
    cfg_idle_lim = '0;

    // R5 reject set: control char stored, no close
    cfg_reject = 1'b1; w0 = we_n; c0 = cl_n;
    send(8'h0D, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5 reject stored", we_n - w0, 1);
    chk("R5 reject no close", cl_n - c0, 0);
    cfg_reject = 1'b0;

    // R1 back-to-back frames, then R7/R9 full count continues (1 already in buffer)
    w0 = we_n; c0 = cl_n;
    send(8'h31, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    send(8'h32, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R1 back-to-back stored", we_n - w0, 2);
    chk("R1 back-to-back byte", int'(last_b), 8'h32);
    send(8'h33, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R7 full close", cl_n - c0, 1);
    chk("R7 full cause", int'(last_c), 2);
    chk("R9 irq with close", irq_n, cl_n);

    // R10 glitch start bit
    w0 = we_n; c0 = cl_n;
    rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk("R10 glitch no store", we_n - w0, 0);
    chk("R10 glitch no close", cl_n - c0, 0);
    send(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10 next char ok", int'(last_b), 8'h5A);

    // R2 seven-bit mode
    cfg_len8 = 1'b0; w0 = we_n;
    send(8'hC1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R2 stored", we_n - w0, 1);
    chk("R2 bit7 zero", int'(last_b), 8'h41);
    cfg_len8 = 1'b1;

    // R3 plain multidrop (buffer holds 2)
    cfg_mdrop = 2'd1; w0 = we_n; c0 = cl_n;
    send(8'h60, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R3 data stored", we_n - w0, 1);
    send(8'h07, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R3 address stored", we_n - w0, 2);
    chk("R3 address byte", int'(last_b), 8'h07);
    chk("R3 address close", cl_n - c0, 1);
    chk("R3 address cause", int'(last_c), 4);

    // R4 filtering multidrop, station 0x22 (buffer holds 1)
    cfg_mdrop = 2'd2; w0 = we_n; c0 = cl_n;
    send(8'h33, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R4 mismatch not stored", we_n - w0, 0);
    chk("R4 mismatch close", cl_n - c0, 1);
    chk("R4 mismatch cause", int'(last_c), 4);
    send(8'h44, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R4 data dropped", we_n - w0, 0);
    send(8'h22, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R4 match stored", we_n - w0, 1);
    chk("R4 match byte", int'(last_b), 8'h22);
    send(8'h45, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R4 data accepted", we_n - w0, 2);
    chk("R4 data byte", int'(last_b), 8'h45);
    chk("R4 no extra close", cl_n - c0, 1);
    chk("R9 irq total", irq_n, cl_n);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule